// File: doc/BRIEF.md
# Fixed-Point Status Flag Generator

This block turns an integer result and the operands that produced it into the fixed-point status flags: carry and low-word carry, overflow and low-word overflow, a sticky summary-overflow bit, and a four-bit condition field. The arithmetic happens elsewhere. The block receives the 64-bit operands, the 64-bit result and a set of enable bits. On a single result-valid strobe it folds them into a registered status word.

Carry is found by comparing each operand, as an unsigned number, against the result. No carry-out is needed from the adder. Overflow is found from the sign bits of the first two operands and of the result. A divide unit can also supply its own overflow decision, which then takes the place of the sign test. Each flag group has its own gate, so one datapath can serve operations that write only some of the flags.

Top module: `fxflag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every status output becomes 0 at that edge.
- R2: The operand list is built in a fixed order: first A, then B when `opb_vld` is 1, then the immediate when `imm_vld` is 1. A is replaced by its bitwise inverse when `inv_a` is 1. Outputs change only at the rising edge where `res_vld` is 1. With `res_vld` low, all outputs hold.
- R3: When `carry_en` is 1, `ca` becomes 1 if any listed operand is unsigned-greater than the 64-bit result, and 0 otherwise. `ca32` applies the same test to bits 31:0. When `carry_en` is 0, both hold.
- R4: `done_mask` bit 0 set keeps `ca` unchanged. `done_mask` bit 1 set keeps `ca32` unchanged.
- R5: When `ovf_en` and `ovf_ok` are both 1, `ov` becomes 1 exactly when the first two listed operands have equal bit 63 and the result's bit 63 differs from theirs. `ov32` applies the same test to bit 31. With only one listed operand and no divide override, both hold.
- R6: When `div_ovf_vld` is 1 and overflow is enabled, `ov` and `ov32` both take the value of `div_ovf`. This applies whatever the operands are.
- R7: Whenever overflow is updated, `so` becomes its old value ORed with the new `ov`. Only reset clears it.
- R8: When `rec_en` is 1, `cr0` becomes {negative, positive, zero, so}, with bit 3 as negative and bit 0 as so. The result is read as signed. The `so` used is the value written in the same update. When `rec_en` is 0, `cr0` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | Result valid strobe; status updates on this cycle |
| opa | input | 64 | Operand A |
| inv_a | input | 1 | Use bitwise inverse of A |
| opb | input | 64 | Operand B |
| opb_vld | input | 1 | Operand B takes part |
| imm | input | 64 | Immediate operand |
| imm_vld | input | 1 | Immediate takes part |
| result | input | 64 | Arithmetic result |
| carry_en | input | 1 | Allow carry flag updates |
| done_mask | input | 2 | Bit 0 keeps ca, bit 1 keeps ca32 |
| ovf_en | input | 1 | Overflow enable |
| ovf_ok | input | 1 | Overflow enable is valid |
| div_ovf_vld | input | 1 | Divide overflow supplied |
| div_ovf | input | 1 | Divide overflow value |
| rec_en | input | 1 | Update condition field |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-word carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-word overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
Every flag appears one rising edge after the cycle in which `res_vld` is sampled high. There is no other latency, and nothing moves in cycles without the strobe. The bench changes inputs only on falling edges. Its reference model advances right after each rising edge, using the inputs that edge sampled, and the full status word is compared at the next falling edge. That falling edge comes before any new stimulus is applied, so every comparison sees exactly the one update that is due.

// File: rtl/fxflag_pkg.sv
package fxflag_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned HALF_W = 32;
  parameter int unsigned NUM_OPS = 3;
  parameter int unsigned CR_W = 4;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
    logic [CR_W-1:0] cr0;
  } fx_status_t;
endpackage

// File: rtl/fxflag_carry.sv
module fxflag_carry #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned NUM_OPS = 3
) (
  input  logic [NUM_OPS-1:0][DATA_W-1:0] ops,
  input  logic [NUM_OPS-1:0]             op_act,
  input  logic [DATA_W-1:0]              result,
  output logic                           carry_full,
  output logic                           carry_half
);
  logic [NUM_OPS-1:0] gt_full;
  logic [NUM_OPS-1:0] gt_half;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
    assign gt_full[g] = op_act[g] && (ops[g] > result);
    assign gt_half[g] = op_act[g] && (ops[g][HALF_W-1:0] > result[HALF_W-1:0]);
  end

  assign carry_full = |gt_full;
  assign carry_half = |gt_half;
endmodule

// File: rtl/fxflag_ovf.sv
module fxflag_ovf #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned NUM_OPS = 3
) (
  input  logic [NUM_OPS-1:0][DATA_W-1:0] ops,
  input  logic [NUM_OPS-1:0]             op_act,
  input  logic [DATA_W-1:0]              result,
  input  logic                           div_vld,
  input  logic                           div_val,
  output logic                           ovf_full,
  output logic                           ovf_half,
  output logic                           ovf_valid
);
  localparam int unsigned MSB_F = DATA_W - 1;
  localparam int unsigned MSB_H = HALF_W - 1;

  logic [DATA_W-1:0] first_op;
  logic [DATA_W-1:0] second_op;
  logic              second_found;
  logic              sign_ovf_f;
  logic              sign_ovf_h;

  // operand slot 0 is always present; pick the lowest active slot above it
  assign first_op = ops[0];

  always_comb begin
    second_op    = '0;
    second_found = 1'b0;
    for (int i = 1; i < NUM_OPS; i++) begin
      if (op_act[i] && !second_found) begin
        second_op    = ops[i];
        second_found = 1'b1;
      end
    end
  end

  assign sign_ovf_f = (first_op[MSB_F] == second_op[MSB_F]) &&
                      (result[MSB_F] != first_op[MSB_F]);
  assign sign_ovf_h = (first_op[MSB_H] == second_op[MSB_H]) &&
                      (result[MSB_H] != first_op[MSB_H]);

  assign ovf_full  = div_vld ? div_val : sign_ovf_f;
  assign ovf_half  = div_vld ? div_val : sign_ovf_h;
  assign ovf_valid = div_vld | second_found;
endmodule

// File: rtl/fxflag_cr.sv
module fxflag_cr #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CR_W   = 4
) (
  input  logic [DATA_W-1:0] result,
  input  logic              so_in,
  output logic [CR_W-1:0]   cr_field
);
  logic is_neg;
  logic is_zero;
  logic is_pos;

  assign is_neg  = result[DATA_W-1];
  assign is_zero = (result == '0);
  assign is_pos  = !is_neg && !is_zero;

  assign cr_field = {is_neg, is_pos, is_zero, so_in};
endmodule

// File: rtl/fxflag_unit.sv
module fxflag_unit
  import fxflag_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_vld,
  input  logic [W-1:0]  opa,
  input  logic          inv_a,
  input  logic [W-1:0]  opb,
  input  logic          opb_vld,
  input  logic [W-1:0]  imm,
  input  logic          imm_vld,
  input  logic [W-1:0]  result,
  input  logic          carry_en,
  input  logic [1:0]    done_mask,
  input  logic          ovf_en,
  input  logic          ovf_ok,
  input  logic          div_ovf_vld,
  input  logic          div_ovf,
  input  logic          rec_en,
  output logic          ca,
  output logic          ca32,
  output logic          ov,
  output logic          ov32,
  output logic          so,
  output logic [CR_W-1:0] cr0
);
  localparam int unsigned SLOT_A   = 0;
  localparam int unsigned SLOT_B   = 1;
  localparam int unsigned SLOT_IMM = 2;

  fx_status_t stat_q;

  logic [NUM_OPS-1:0][W-1:0] ops;
  logic [NUM_OPS-1:0]        op_act;

  logic carry_full, carry_half;
  logic ovf_full, ovf_half, ovf_valid;
  logic ovf_upd;

  logic            ca_n, ca32_n, ov_n, ov32_n, so_n;
  logic [CR_W-1:0] cr_calc;
  logic [CR_W-1:0] cr_n;

  always_comb begin
    ops            = '0;
    ops[SLOT_A]    = inv_a ? ~opa : opa;
    ops[SLOT_B]    = opb;
    ops[SLOT_IMM]  = imm;
    op_act         = '0;
    op_act[SLOT_A]   = 1'b1;
    op_act[SLOT_B]   = opb_vld;
    op_act[SLOT_IMM] = imm_vld;
  end

  fxflag_carry #(.DATA_W(W), .HALF_W(HW), .NUM_OPS(NUM_OPS)) u_carry (
    .ops        (ops),
    .op_act     (op_act),
    .result     (result),
    .carry_full (carry_full),
    .carry_half (carry_half)
  );

  fxflag_ovf #(.DATA_W(W), .HALF_W(HW), .NUM_OPS(NUM_OPS)) u_ovf (
    .ops       (ops),
    .op_act    (op_act),
    .result    (result),
    .div_vld   (div_ovf_vld),
    .div_val   (div_ovf),
    .ovf_full  (ovf_full),
    .ovf_half  (ovf_half),
    .ovf_valid (ovf_valid)
  );

  assign ovf_upd = ovf_en && ovf_ok && ovf_valid;

  always_comb begin
    ca_n   = stat_q.ca;
    ca32_n = stat_q.ca32;
    if (carry_en) begin
      if (!done_mask[0]) ca_n   = carry_full;
      if (!done_mask[1]) ca32_n = carry_half;
    end
  end

  always_comb begin
    ov_n   = stat_q.ov;
    ov32_n = stat_q.ov32;
    so_n   = stat_q.so;
    if (ovf_upd) begin
      ov_n   = ovf_full;
      ov32_n = ovf_half;
      so_n   = stat_q.so | ovf_full;
    end
  end

  fxflag_cr #(.DATA_W(W), .CR_W(CR_W)) u_cr (
    .result   (result),
    .so_in    (so_n),
    .cr_field (cr_calc)
  );

  assign cr_n = rec_en ? cr_calc : stat_q.cr0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (res_vld) begin
      stat_q.ca   <= ca_n;
      stat_q.ca32 <= ca32_n;
      stat_q.ov   <= ov_n;
      stat_q.ov32 <= ov32_n;
      stat_q.so   <= so_n;
      stat_q.cr0  <= cr_n;
    end
  end

  assign ca   = stat_q.ca;
  assign ca32 = stat_q.ca32;
  assign ov   = stat_q.ov;
  assign ov32 = stat_q.ov32;
  assign so   = stat_q.so;
  assign cr0  = stat_q.cr0;
endmodule

// File: rtl/fxflag_unit_chk.sv
module fxflag_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       res_vld,
  input logic       carry_en,
  input logic [1:0] done_mask,
  input logic       ovf_en,
  input logic       ovf_ok,
  input logic       rec_en,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       ov32,
  input logic       so,
  input logic [3:0] cr0
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ({ca, ca32, ov, ov32, so, cr0} == 9'd0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !res_vld |=> $stable({ca, ca32, ov, ov32, so, cr0})); // R2

  AST_CARRY_GATE: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !carry_en) |=> $stable({ca, ca32})); // R3

  AST_CA_MASK: assert property (@(posedge clk) disable iff (rst)
    (res_vld && done_mask[0]) |=> $stable(ca)); // R4

  AST_CA32_MASK: assert property (@(posedge clk) disable iff (rst)
    (res_vld && done_mask[1]) |=> $stable(ca32)); // R4

  AST_OVF_GATE: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !(ovf_en && ovf_ok)) |=> $stable({ov, ov32, so})); // R5

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    so |=> so); // R7

  AST_CR_SO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (res_vld && rec_en) |=> (cr0[0] == so)); // R8

  AST_CR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !rec_en) |=> $stable(cr0)); // R8
endmodule

bind fxflag_unit fxflag_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_vld   (res_vld),
  .carry_en  (carry_en),
  .done_mask (done_mask),
  .ovf_en    (ovf_en),
  .ovf_ok    (ovf_ok),
  .rec_en    (rec_en),
  .ca        (ca),
  .ca32      (ca32),
  .ov        (ov),
  .ov32      (ov32),
  .so        (so),
  .cr0       (cr0)
);

// File: tb/sim_fxflag_unit.sv
`timescale 1ns/1ps
module sim_fxflag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_vld = 1'b0;
  logic [63:0] opa = '0, opb = '0, imm = '0, result = '0;
  logic        inv_a = 1'b0, opb_vld = 1'b0, imm_vld = 1'b0;
  logic        carry_en = 1'b0, ovf_en = 1'b0, ovf_ok = 1'b0;
  logic [1:0]  done_mask = 2'b00;
  logic        div_ovf_vld = 1'b0, div_ovf = 1'b0, rec_en = 1'b0;
  logic        ca, ca32, ov, ov32, so;
  logic [3:0]  cr0;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit m_ca, m_ca32, m_ov, m_ov32, m_so;
  bit [3:0] m_cr;

  always #2.5 clk = ~clk;

  fxflag_unit u0 (
    .clk(clk), .rst(rst), .res_vld(res_vld), .opa(opa), .inv_a(inv_a),
    .opb(opb), .opb_vld(opb_vld), .imm(imm), .imm_vld(imm_vld),
    .result(result), .carry_en(carry_en), .done_mask(done_mask),
    .ovf_en(ovf_en), .ovf_ok(ovf_ok), .div_ovf_vld(div_ovf_vld),
    .div_ovf(div_ovf), .rec_en(rec_en), .ca(ca), .ca32(ca32), .ov(ov),
    .ov32(ov32), .so(so), .cr0(cr0)
  );

  task automatic model_edge();
    logic [63:0] q[$];
    longint sa, sb, sr;
    int      s32a, s32b, s32r;
    bit      any_gt, any_gt32;
    if (rst) begin
      m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = 0;
      return;
    end
    if (!res_vld) return;
    q.push_back(inv_a ? ~opa : opa);
    if (opb_vld) q.push_back(opb);
    if (imm_vld) q.push_back(imm);
    if (carry_en) begin
      any_gt = 0; any_gt32 = 0;
      foreach (q[i]) begin
        if (q[i] > result) any_gt = 1;
        if (q[i][31:0] > result[31:0]) any_gt32 = 1;
      end
      if (!done_mask[0]) m_ca = any_gt;
      if (!done_mask[1]) m_ca32 = any_gt32;
    end
    if (ovf_en && ovf_ok) begin
      if (div_ovf_vld) begin
        m_ov = div_ovf; m_ov32 = div_ovf; m_so = m_so | div_ovf;
      end else if (q.size() >= 2) begin
        sa = $signed(q[0]); sb = $signed(q[1]); sr = $signed(result);
        s32a = $signed(q[0][31:0]); s32b = $signed(q[1][31:0]);
        s32r = $signed(result[31:0]);
        m_ov   = ((sa < 0) == (sb < 0)) && ((sr < 0) != (sa < 0));
        m_ov32 = ((s32a < 0) == (s32b < 0)) && ((s32r < 0) != (s32a < 0));
        m_so = m_so | m_ov;
      end
    end
    if (rec_en) begin
      sr = $signed(result);
      m_cr = {sr < 0, sr > 0, sr == 0, m_so};
    end
  endtask

  task automatic compare(input string tag);
    logic [8:0] act, exp;
    act = {ca, ca32, ov, ov32, so, cr0};
    exp = {m_ca, m_ca32, m_ov, m_ov32, m_so, m_cr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ca,ca32,ov,ov32,so,cr0} actual %b expected %b", tag, act, exp);
    end
  endtask

  // one clock: sample at rising edge, compare at the following falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_in();
    res_vld = 1; opa = 0; opb = 0; imm = 0; result = 0;
    inv_a = 0; opb_vld = 1; imm_vld = 0; carry_en = 0; done_mask = 0;
    ovf_en = 0; ovf_ok = 0; div_ovf_vld = 0; div_ovf = 0; rec_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1;
    tick("R1");
    tick("R1");
    @(negedge clk); rst = 0;
    clear_in(); res_vld = 0;
    tick("R1");

    // R3 carry, full and half
    clear_in(); carry_en = 1; opa = 5; opb = 3; result = 2;
    tick("R3");
    opa = 1; opb = 1; result = 2;
    tick("R3");
    opa = 64'h0000_0000_FFFF_FFFF; opb = 0; result = 64'h0000_0001_0000_0000;
    tick("R3");
    carry_en = 0; opa = 64'hFFFF_FFFF_FFFF_FFFF; result = 0;
    tick("R3");

    // R2 inversion, immediate, idle hold
    carry_en = 1; inv_a = 1; opa = 0; opb_vld = 0; result = 64'h10;
    tick("R2");
    inv_a = 0; opa = 0; imm_vld = 1; imm = 64'h20; result = 64'h10;
    tick("R2");
    res_vld = 0; imm = 0; opa = 0; result = 64'hFFFF_FFFF_FFFF_FFFF;
    tick("R2");

    // R4 masks
    clear_in(); carry_en = 1; result = 64'hFFFF_FFFF_FFFF_FFFF;
    done_mask = 2'b01;
    tick("R4");
    done_mask = 2'b10; opa = 64'h0000_0002_0000_0005; result = 64'h0000_0001_0000_0006;
    tick("R4");

    // R5 overflow
    clear_in(); ovf_en = 1; ovf_ok = 1;
    opa = 64'h7FFF_FFFF_FFFF_FFFF; opb = 1; result = 64'h8000_0000_0000_0000;
    tick("R5");
    opa = 64'h0000_0000_7FFF_FFFF; opb = 64'h0000_0000_7FFF_FFFF; result = 64'h0000_0000_FFFF_FFFE;
    tick("R5");
    opb_vld = 0; opa = 64'h7FFF_FFFF_FFFF_FFFF; result = 0;
    tick("R5");
    opb_vld = 0; imm_vld = 1; imm = 64'h8000_0000_0000_0000;
    opa = 64'h8000_0000_0000_0000; result = 0;
    tick("R5");
    ovf_ok = 0; opb_vld = 1; opb = 1; imm_vld = 0; opa = 1; result = 2;
    tick("R5");

    // R7 sticky survives a clean overflow update
    ovf_ok = 1; opa = 1; opb = 1; result = 2;
    tick("R7");

    // R6 divide override
    div_ovf_vld = 1; div_ovf = 0; opa = 64'h7FFF_FFFF_FFFF_FFFF; opb = 1;
    result = 64'h8000_0000_0000_0000;
    tick("R6");
    div_ovf = 1; opa = 0; opb = 0; result = 0;
    tick("R6");

    // R8 condition field
    clear_in(); rec_en = 1; result = 64'h8000_0000_0000_0001;
    tick("R8");
    result = 5;
    tick("R8");
    result = 0;
    tick("R8");
    rec_en = 0; result = 64'hFFFF_FFFF_FFFF_FFFF;
    tick("R8");

    // R1 reset clears sticky state
    rst = 1;
    tick("R1");
    rst = 0;
    clear_in(); rec_en = 1; result = 7;
    tick("R8");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      res_vld     = ($urandom % 4) != 0;
      opa         = {$urandom, $urandom};
      opb         = {$urandom, $urandom};
      imm         = {$urandom, $urandom};
      inv_a       = $urandom % 2;
      opb_vld     = $urandom % 2;
      imm_vld     = $urandom % 2;
      result      = ($urandom % 2) ? opa + opb : {$urandom, $urandom};
      if (($urandom % 8) == 0) result = 0;
      carry_en    = $urandom % 2;
      done_mask   = $urandom % 4;
      ovf_en      = $urandom % 2;
      ovf_ok      = ($urandom % 4) != 0;
      div_ovf_vld = ($urandom % 6) == 0;
      div_ovf     = $urandom % 2;
      rec_en      = $urandom % 2;
      rst         = ($urandom % 64) == 0;
      tick("R3,R5,R6,R8");
    end
    rst = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule